// File: doc/BRIEF.md
# Clock and reset control registers

This block is the software-visible register file of a power, reset and clock controller. A host reaches it through a plain 32-bit register port: address, write enable and write data for stores, and read enable with registered read data for loads. It holds nine word registers: the oscillator setup, three primary PLL setup words (core, memory, network), two secondary PLL setup words (memory, network), the core clock selector, a peripheral reset word and a clock mux status word.

No real oscillator, PLL or clock switch stands behind the registers. The hardware-owned status bits are modelled as permanently good. The oscillator ready flag and the PLL lock and internal-feedback flags read as 1 whatever software stores. The core clock select bit and the low peripheral reset bits leave the block as ports. Addresses that match no register read as zero and drop stores.

Top module: `clkrst_csr`

## Requirements
- R1: After reset, the oscillator word (offset 0x00) reads 0xC0000000, with enable bit 30 and ready bit 31 set. Each primary PLL word (offsets 0x04, 0x08, 0x10) reads 0x820187C1: reference divider bits 5:0 = 1, feedback divider bits 14:6 = 0x1F, output divider bits 17:15 = 3, feedback-select bit 25 = 1 and lock bit 31 = 1. The clock select word (0x24) reads 0x1. The secondary PLL words (0x0C, 0x14), the peripheral reset word (0x28) and the mux status word (0x2C) read 0.
- R2: A store to the oscillator word keeps the written value except that bit 31 always reads back 1.
- R3: A store to any primary PLL word keeps the written value except that bits 25 and 31 always read back 1.
- R4: Stores to the secondary PLL words, the clock select word, the peripheral reset word and the mux status word are kept unchanged, all 32 bits.
- R5: The nine registers sit at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x24, 0x28 and 0x2C. Only word accesses exist.
- R6: A read of any address that is not one of the nine offsets, including a misaligned address (bits 1:0 not zero), returns 0.
- R7: A store to any address that is not one of the nine offsets leaves all nine registers and both output ports unchanged.
- R8: rdata_o carries the addressed value on the cycle after re_i is sampled high, and holds its value while re_i is low.
- R9: core_clk_sel_o equals bit 0 of the clock select word, and periph_rst_o equals the low PRST_W bits of the peripheral reset word. Both change on the cycle after the store.
- R10: When a read and a write hit the same register on the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read enable |
| rdata_o | output | 32 | Read data, registered |
| core_clk_sel_o | output | 1 | Core clock select, bit 0 of the clock select word |
| periph_rst_o | output | PRST_W | Peripheral reset bits |

## Verification
The assertions watch on every cycle that oscillator and PLL reads always return their forced status bits, that unmapped reads return zero, that rdata_o holds while no read is issued, and that the two output ports follow stores to their registers and stay still otherwise. Only the bench's scenarios show the reset values, full read-back of every written bit, and that an unmapped or misaligned store disturbs none of the nine registers. The bench also covers the read-before-write ordering when both hit one address on the same cycle. It sweeps every address of the default 8-bit space with two complementary data patterns against an arithmetic model.

// File: rtl/clkrst_csr_pkg.sv
package clkrst_csr_pkg;

  localparam int DATA_W   = 32;
  localparam int NUM_REGS = 9;

  typedef logic [DATA_W-1:0] word_t;

  typedef enum int {
    IDX_OSC     = 0,
    IDX_CPLL0   = 1,
    IDX_MPLL0   = 2,
    IDX_MPLL1   = 3,
    IDX_NPLL0   = 4,
    IDX_NPLL1   = 5,
    IDX_CLKSEL  = 6,
    IDX_PRST    = 7,
    IDX_MUXSTAT = 8
  } reg_idx_e;

  localparam int OSC_EN_BIT   = 30;
  localparam int OSC_RDY_BIT  = 31;
  localparam int PLL_FSE_BIT  = 25;
  localparam int PLL_LOCK_BIT = 31;

  localparam word_t PLL_DIVR_RST = 32'd1;
  localparam word_t PLL_DIVF_RST = 32'h1F;
  localparam word_t PLL_DIVQ_RST = 32'd3;

  localparam word_t OSC_FORCE = word_t'(1) << OSC_RDY_BIT;
  localparam word_t PLL_FORCE = (word_t'(1) << PLL_FSE_BIT) | (word_t'(1) << PLL_LOCK_BIT);
  localparam word_t OSC_RST   = OSC_FORCE | (word_t'(1) << OSC_EN_BIT);
  localparam word_t PLL_RST   = PLL_FORCE | PLL_DIVR_RST | (PLL_DIVF_RST << 6) | (PLL_DIVQ_RST << 15);

  function automatic word_t reg_offset(int idx);
    case (idx)
      IDX_OSC:     return 32'h00;
      IDX_CPLL0:   return 32'h04;
      IDX_MPLL0:   return 32'h08;
      IDX_MPLL1:   return 32'h0C;
      IDX_NPLL0:   return 32'h10;
      IDX_NPLL1:   return 32'h14;
      IDX_CLKSEL:  return 32'h24;
      IDX_PRST:    return 32'h28;
      default:     return 32'h2C;
    endcase
  endfunction

  function automatic logic is_pll_primary(int idx);
    return (idx == IDX_CPLL0) || (idx == IDX_MPLL0) || (idx == IDX_NPLL0);
  endfunction

  function automatic word_t reg_force(int idx);
    if (idx == IDX_OSC) return OSC_FORCE;
    if (is_pll_primary(idx)) return PLL_FORCE;
    return '0;
  endfunction

  function automatic word_t reg_reset(int idx);
    if (idx == IDX_OSC) return OSC_RST;
    if (is_pll_primary(idx)) return PLL_RST;
    if (idx == IDX_CLKSEL) return 32'h1;
    return '0;
  endfunction

endpackage

// File: rtl/clkrst_addr_dec.sv
module clkrst_addr_dec
  import clkrst_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] hit_o
);

  // full-address compare: misaligned addresses never hit
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    localparam word_t OFF = reg_offset(i);
    assign hit_o[i] = (addr_i == ADDR_W'(OFF));
  end

endmodule

// File: rtl/clkrst_reg.sv
module clkrst_reg
  import clkrst_csr_pkg::*;
#(
  parameter word_t RST_VAL    = '0,
  parameter word_t FORCE_MASK = '0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  word_t wdata_i,
  output word_t q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (we_i) q_o <= wdata_i | FORCE_MASK;
  end

endmodule

// File: rtl/clkrst_rd_mux.sv
module clkrst_rd_mux
  import clkrst_csr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 re_i,
  input  logic [NUM_REGS-1:0]  hit_i,
  input  word_t [NUM_REGS-1:0] regs_i,
  output word_t                rdata_o
);

  word_t sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_REGS; i++) sel |= regs_i[i] & {DATA_W{hit_i[i]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= sel;
  end

endmodule

// File: rtl/clkrst_csr.sv
module clkrst_csr
  import clkrst_csr_pkg::*;
#(
  parameter int ADDR_W = 8,  // must cover offset 0x2C
  parameter int PRST_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  input  logic              re_i,
  output logic [31:0]       rdata_o,
  output logic              core_clk_sel_o,
  output logic [PRST_W-1:0] periph_rst_o
);

  logic [NUM_REGS-1:0]  hit;
  word_t [NUM_REGS-1:0] regs;

  clkrst_addr_dec #(.ADDR_W(ADDR_W)) i_dec (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    clkrst_reg #(
      .RST_VAL    (reg_reset(i)),
      .FORCE_MASK (reg_force(i))
    ) i_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we_i & hit[i]),
      .wdata_i (wdata_i),
      .q_o     (regs[i])
    );
  end

  clkrst_rd_mux i_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .re_i    (re_i),
    .hit_i   (hit),
    .regs_i  (regs),
    .rdata_o (rdata_o)
  );

  assign core_clk_sel_o = regs[IDX_CLKSEL][0];
  assign periph_rst_o   = regs[IDX_PRST][PRST_W-1:0];

endmodule

// File: rtl/clkrst_csr_chk.sv
module clkrst_csr_chk #(
  parameter int ADDR_W = 8,
  parameter int PRST_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [31:0]       wdata_i,
  input logic              re_i,
  input logic [31:0]       rdata_o,
  input logic              core_clk_sel_o,
  input logic [PRST_W-1:0] periph_rst_o
);

  logic a_osc, a_pll, a_sel, a_prst, a_mapped;

  always_comb begin
    a_osc  = addr_i == ADDR_W'('h00);
    a_pll  = addr_i == ADDR_W'('h04) || addr_i == ADDR_W'('h08) || addr_i == ADDR_W'('h10);
    a_sel  = addr_i == ADDR_W'('h24);
    a_prst = addr_i == ADDR_W'('h28);
    a_mapped = a_osc || a_pll || a_sel || a_prst ||
               addr_i == ADDR_W'('h0C) || addr_i == ADDR_W'('h14) || addr_i == ADDR_W'('h2C);
  end

  p_osc_rdy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && a_osc |=> rdata_o[31]);

  p_pll_flags_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && a_pll |=> rdata_o[31] && rdata_o[25]);

  p_unmapped_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && !a_mapped |=> rdata_o == 32'h0);

  p_rdata_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  p_sel_follow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && a_sel |=> core_clk_sel_o == $past(wdata_i[0]));

  p_prst_follow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && a_prst |=> periph_rst_o == $past(wdata_i[PRST_W-1:0]));

  p_ports_still_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (a_sel || a_prst)) |=> $stable(core_clk_sel_o) && $stable(periph_rst_o));

endmodule

bind clkrst_csr clkrst_csr_chk #(.ADDR_W(ADDR_W), .PRST_W(PRST_W)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .addr_i         (addr_i),
  .we_i           (we_i),
  .wdata_i        (wdata_i),
  .re_i           (re_i),
  .rdata_o        (rdata_o),
  .core_clk_sel_o (core_clk_sel_o),
  .periph_rst_o   (periph_rst_o)
);

// File: tb/test_clkrst_csr.sv
module test_clkrst_csr;

  localparam int ADDR_W = 8;
  localparam int PRST_W = 6;
  localparam int NREG   = 9;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              we = 1'b0;
  logic [31:0]       wdata = '0;
  logic              re = 1'b0;
  logic [31:0]       rdata;
  logic              clk_sel;
  logic [PRST_W-1:0] prst;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [NREG];

  always #10 clk = ~clk;

  clkrst_csr #(.ADDR_W(ADDR_W), .PRST_W(PRST_W)) i_clkrst_csr (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .rdata_o(rdata), .core_clk_sel_o(clk_sel), .periph_rst_o(prst)
  );

  function automatic logic [7:0] off_of(int i);
    case (i)
      0: return 8'h00; 1: return 8'h04; 2: return 8'h08; 3: return 8'h0C;
      4: return 8'h10; 5: return 8'h14; 6: return 8'h24; 7: return 8'h28;
      default: return 8'h2C;
    endcase
  endfunction

  function automatic int idx_of(logic [7:0] a);
    for (int i = 0; i < NREG; i++) if (off_of(i) == a) return i;
    return -1;
  endfunction

  function automatic logic [31:0] stored(int i, logic [31:0] d);
    if (i == 0) return d | 32'h8000_0000;
    if (i == 1 || i == 2 || i == 4) return d | 32'h8200_0000;
    return d;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic chk_ports(string req);
    chk(req, {31'h0, clk_sel}, {31'h0, model[6][0]});
    chk(req, {26'h0, prst}, {26'h0, model[7][PRST_W-1:0]});
  endtask

  task automatic chk_all(string req);
    logic [31:0] d;
    for (int i = 0; i < NREG; i++) begin
      rd(off_of(i), d);
      chk(req, d, model[i]);
    end
  endtask

  task automatic sweep(logic invert);
    logic [31:0] d, pat;
    for (int a = 0; a < 256; a++) begin
      pat = {a[7:0], ~a[7:0], a[7:0] ^ 8'h5A, 8'hC3 ^ a[7:0]};
      if (invert) pat = ~pat;
      wr(8'(a), pat);
      if (idx_of(8'(a)) >= 0) begin
        model[idx_of(8'(a))] = stored(idx_of(8'(a)), pat);
        rd(8'(a), d);
        if (idx_of(8'(a)) == 0) chk("R2", d, model[0]);
        else if (idx_of(8'(a)) inside {1, 2, 4}) chk("R3", d, model[idx_of(8'(a))]);
        else chk("R4 R5", d, model[idx_of(8'(a))]);
        chk_ports("R9");
      end else begin
        rd(8'(a), d);
        chk("R6", d, 32'h0);
        chk_all("R7");
        chk_ports("R7");
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, held;
    for (int i = 0; i < NREG; i++) model[i] = 32'h0;
    model[0] = 32'hC000_0000;
    model[1] = 32'h8201_87C1;
    model[2] = 32'h8201_87C1;
    model[4] = 32'h8201_87C1;
    model[6] = 32'h1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", rdata, 32'h0);
    chk_ports("R1");
    chk_all("R1");

    sweep(1'b0);
    sweep(1'b1);

    // R8: rdata_o holds while re_i is low, even across writes
    rd(8'h00, held);
    chk("R8", held, model[0]);
    wr(8'h00, 32'h0);
    model[0] = stored(0, 32'h0);
    repeat (3) @(negedge clk);
    chk("R8", rdata, held);

    // R10: read and write to the same register on one cycle
    @(negedge clk); addr = 8'h28; wdata = 32'h0000_002A; we = 1'b1; re = 1'b1;
    @(negedge clk); we = 1'b0; re = 1'b0;
    chk("R10", rdata, model[7]);
    model[7] = 32'h0000_002A;
    rd(8'h28, d);
    chk("R10", d, model[7]);
    chk_ports("R9");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule